// File: doc/BRIEF.md
# Multiplexed Burst Bus Master

This block drives one 32-bit bus on which address and data share the same wires. The core presents one request: a start address, a direction, a size code and the width of the memory port behind the address (8, 16 or 32 bits). The master then runs one address cycle followed by one data cycle per transfer. A transfer ends when the slave's ready input is sampled high. The size code rides on the two lowest bus bits during the address cycle, so an external decoder knows the burst length before any data moves.

Beside the shared bus the master drives the following outputs:
- an active-low address strobe;
- an address latch enable, together with a copy of opposite polarity;
- a 4-bit low-order address that steps on every ready, by an amount set by the port width.

Between transactions the master can give up the bus for a hold request, with all of its drivers released. It can also park in halt, where it drives a fixed mix of the last address, last data and last size code.

Top module: `mux_burst_master`

## Requirements
- R1: After reset the strobe is high, latch enable is low with its inverse high, control drivers are enabled, and hold acknowledge, done and read-valid are all low.
- R2: One cycle after a request is accepted in idle, the strobe is low and latch enable high for exactly one cycle. The bus carries request address bits 31:2 with the size code (transfers minus one) in bits 1:0.
- R3: The latch enable output is low in every data cycle and the strobe is high. The inverse latch output is the complement of the latch enable whenever control drivers are on.
- R4: A burst consumes exactly size+1 cycles in which ready is high. The done output pulses for one cycle in the cycle after the final ready, and the master is then idle.
- R5: Port code 00 is 8-bit, 01 is 16-bit, and 10 or 11 is 32-bit. The partial address starts at request address bits 3:0 with bit 0 cleared on a 16-bit port and bits 1:0 cleared on a 32-bit port. It then adds 1, 2 or 4 (modulo 16) on each ready, and holds during wait cycles.
- R6: In a write data cycle the bus is driven with the request word for the current transfer (word i at bits 32i+31:32i of the write data input). All four byte lanes are used on a 32-bit port, lanes 0-1 on a 16-bit port and lane 0 on an 8-bit port. Unused lanes are driven as zero.
- R7: In a read data cycle the bus drivers are off. One cycle after each ready, read-valid pulses with the bus value sampled at that ready (unused lanes zeroed as in R6) and the transfer index.
- R8: A hold request seen in idle wins over a pending request. One cycle later the acknowledge is high and both driver enables are low, and requests are ignored. One cycle after the hold request drops, the control drivers are on with strobe high and latch enable low.
- R9: A hold request raised during an address or data cycle has no effect until the transaction completes.
- R10: In halt after a write, the bus carries bits 31:2 of the last data cycle's bus value and bits 1:0 carry the last size code.
- R11: In halt after a read, the bus carries last address bits 31:4, the partial address bits 3:2 of the last data cycle, and the last size code in bits 1:0.
- R12: Halt is entered one cycle after the halt input is seen high in idle. While halted, requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Core requests a transaction |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Start byte address |
| req_size_i | input | 2 | Number of transfers minus one |
| req_port_i | input | 2 | Port width code (00 8-bit, 01 16-bit, 1x 32-bit) |
| req_wdata_i | input | 128 | Write words, word i in bits 32i+31:32i |
| hold_req_i | input | 1 | Request to float the bus |
| halt_i | input | 1 | Enter halt and park the bus |
| rdy_i | input | 1 | Slave ready, ends one transfer |
| ad_i | input | 32 | Bus value seen at the pins |
| ad_o | output | 32 | Bus value driven |
| ad_oe_o | output | 1 | Bus driver enable |
| ctl_oe_o | output | 1 | Enable for strobe, latch enables and partial address |
| ads_no | output | 1 | Address strobe, active low |
| ale_o | output | 1 | Address latch enable, active high |
| ale_no | output | 1 | Inverse of address latch enable |
| pa_o | output | 4 | Partial low address |
| hold_ack_o | output | 1 | Bus is floated for hold |
| done_o | output | 1 | One-cycle pulse at end of transaction |
| rd_valid_o | output | 1 | Read word valid |
| rd_data_o | output | 32 | Captured read word |
| rd_idx_o | output | 2 | Transfer index of the read word |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, a 2-bit size code (up to four transfers) and a 4-bit partial address. At these values every combination of port width, size code, direction and four start offsets fits in one sweep. Those offsets make the partial address wrap past 15 on 8-bit and 32-bit ports. The sweep also inserts a wait cycle inside each longer burst. Separate runs cover halt after a read and after a write, hold in idle and during a burst, and requests offered while held or halted.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int BUS_W  = 32;
    localparam int SIZE_W = 2;
    localparam int PA_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_HOLD = 3'd3,
        ST_HALT = 3'd4
    } mbm_state_e;

    typedef enum logic [1:0] {
        PW_8   = 2'b00,
        PW_16  = 2'b01,
        PW_32  = 2'b10,
        PW_32X = 2'b11
    } port_w_e;

endpackage

// File: rtl/mbm_lane_fmt.sv
module mbm_lane_fmt #(
    parameter int BUS_W = 32
) (
    input  logic [1:0]       pw_i,
    input  logic [BUS_W-1:0] word_i,
    output logic [BUS_W-1:0] word_o
);
    localparam int LANES = BUS_W / 8;

    logic [LANES-1:0] lane_on;

    // lanes carried by each port width, lowest lanes first
    always_comb begin
        unique case (pw_i)
            mbm_pkg::PW_8:  lane_on = LANES'(1);
            mbm_pkg::PW_16: lane_on = LANES'(3);
            default:        lane_on = '1;
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign word_o[k*8 +: 8] = lane_on[k] ? word_i[k*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/mbm_part_addr.sv
module mbm_part_addr #(
    parameter int PA_W = 4
) (
    input  logic [1:0]      req_pw_i,
    input  logic [PA_W-1:0] req_start_i,
    input  logic [1:0]      cur_pw_i,
    input  logic [PA_W-1:0] cur_i,
    output logic [PA_W-1:0] init_o,
    output logic [PA_W-1:0] next_o
);
    logic [PA_W-1:0] align_mask;
    logic [PA_W-1:0] step;

    always_comb begin
        unique case (req_pw_i)
            mbm_pkg::PW_8:  align_mask = '1;
            mbm_pkg::PW_16: align_mask = ~PA_W'(1);
            default:        align_mask = ~PA_W'(3);
        endcase
    end

    always_comb begin
        unique case (cur_pw_i)
            mbm_pkg::PW_8:  step = PA_W'(1);
            mbm_pkg::PW_16: step = PA_W'(2);
            default:        step = PA_W'(4);
        endcase
    end

    assign init_o = req_start_i & align_mask;
    assign next_o = cur_i + step;

endmodule

// File: rtl/mbm_park.sv
module mbm_park #(
    parameter int BUS_W  = 32,
    parameter int SIZE_W = 2
) (
    input  logic              last_wr_i,
    input  logic [BUS_W-1:4]  last_addr_i,
    input  logic [BUS_W-1:2]  last_data_i,
    input  logic [3:2]        last_pa_i,
    input  logic [SIZE_W-1:0] last_size_i,
    output logic [BUS_W-1:0]  park_o
);
    always_comb begin
        if (last_wr_i) begin
            park_o = {last_data_i, last_size_i};
        end else begin
            park_o = {last_addr_i, last_pa_i, last_size_i};
        end
    end

endmodule

// File: rtl/mux_burst_master.sv
module mux_burst_master #(
    parameter int BUS_W  = mbm_pkg::BUS_W,
    parameter int SIZE_W = mbm_pkg::SIZE_W,
    parameter int PA_W   = mbm_pkg::PA_W
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              req_valid_i,
    input  logic                              req_write_i,
    input  logic [BUS_W-1:0]                  req_addr_i,
    input  logic [SIZE_W-1:0]                 req_size_i,
    input  logic [1:0]                        req_port_i,
    input  logic [(1<<SIZE_W)*BUS_W-1:0]      req_wdata_i,
    input  logic                              hold_req_i,
    input  logic                              halt_i,
    input  logic                              rdy_i,
    input  logic [BUS_W-1:0]                  ad_i,
    output logic [BUS_W-1:0]                  ad_o,
    output logic                              ad_oe_o,
    output logic                              ctl_oe_o,
    output logic                              ads_no,
    output logic                              ale_o,
    output logic                              ale_no,
    output logic [PA_W-1:0]                   pa_o,
    output logic                              hold_ack_o,
    output logic                              done_o,
    output logic                              rd_valid_o,
    output logic [BUS_W-1:0]                  rd_data_o,
    output logic [SIZE_W-1:0]                 rd_idx_o
);
    import mbm_pkg::*;

    localparam int BEATS = 1 << SIZE_W;
    localparam int WD_W  = BEATS * BUS_W;

    typedef struct packed {
        mbm_state_e         state;
        logic               wr;
        logic [SIZE_W-1:0]  size;
        logic [1:0]         pw;
        logic [BUS_W-1:2]   addr;
        logic [WD_W-1:0]    wdata;
        logic [SIZE_W-1:0]  beat;
        logic [PA_W-1:0]    pa;
        logic               done;
        logic               rd_valid;
        logic [BUS_W-1:0]   rd_data;
        logic [SIZE_W-1:0]  rd_idx;
        logic               last_wr;
        logic [BUS_W-1:4]   last_addr;
        logic [BUS_W-1:2]   last_data;
        logic [3:2]         last_pa;
        logic [SIZE_W-1:0]  last_size;
    } mbm_regs_t;

    mbm_regs_t q, d;

    logic [BUS_W-1:0] cur_word;
    logic [BUS_W-1:0] wr_fmt;
    logic [BUS_W-1:0] rd_fmt;
    logic [BUS_W-1:0] park_val;
    logic [PA_W-1:0]  pa_init;
    logic [PA_W-1:0]  pa_next;

    assign cur_word = q.wdata[q.beat*BUS_W +: BUS_W];

    mbm_lane_fmt #(.BUS_W(BUS_W)) u_wr_fmt (
        .pw_i   (q.pw),
        .word_i (cur_word),
        .word_o (wr_fmt)
    );

    mbm_lane_fmt #(.BUS_W(BUS_W)) u_rd_fmt (
        .pw_i   (q.pw),
        .word_i (ad_i),
        .word_o (rd_fmt)
    );

    mbm_part_addr #(.PA_W(PA_W)) u_pa (
        .req_pw_i    (req_port_i),
        .req_start_i (req_addr_i[PA_W-1:0]),
        .cur_pw_i    (q.pw),
        .cur_i       (q.pa),
        .init_o      (pa_init),
        .next_o      (pa_next)
    );

    mbm_park #(.BUS_W(BUS_W), .SIZE_W(SIZE_W)) u_park (
        .last_wr_i   (q.last_wr),
        .last_addr_i (q.last_addr),
        .last_data_i (q.last_data),
        .last_pa_i   (q.last_pa),
        .last_size_i (q.last_size),
        .park_o      (park_val)
    );

    // next-state computation
    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.rd_valid = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (hold_req_i) begin
                    d.state = ST_HOLD;
                end else if (halt_i) begin
                    d.state = ST_HALT;
                end else if (req_valid_i) begin
                    d.state = ST_ADDR;
                    d.wr    = req_write_i;
                    d.size  = req_size_i;
                    d.pw    = req_port_i;
                    d.addr  = req_addr_i[BUS_W-1:2];
                    d.wdata = req_wdata_i;
                    d.beat  = '0;
                    d.pa    = pa_init;
                end
            end
            ST_ADDR: begin
                d.state = ST_DATA;
            end
            ST_DATA: begin
                if (rdy_i) begin
                    d.pa   = pa_next;
                    d.beat = q.beat + 1'b1;
                    if (!q.wr) begin
                        d.rd_valid = 1'b1;
                        d.rd_data  = rd_fmt;
                        d.rd_idx   = q.beat;
                    end
                    if (q.beat == q.size) begin
                        d.state     = ST_IDLE;
                        d.done      = 1'b1;
                        d.last_wr   = q.wr;
                        d.last_addr = q.addr[BUS_W-1:4];
                        d.last_data = wr_fmt[BUS_W-1:2];
                        d.last_pa   = q.pa[3:2];
                        d.last_size = q.size;
                    end
                end
            end
            ST_HOLD: begin
                if (!hold_req_i) begin
                    d.state = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (!halt_i) begin
                    d.state = ST_IDLE;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // pin decode from registered state
    always_comb begin
        ad_o    = '0;
        ad_oe_o = 1'b1;
        unique case (q.state)
            ST_ADDR: ad_o = {q.addr, q.size};
            ST_DATA: begin
                ad_oe_o = q.wr;
                ad_o    = q.wr ? wr_fmt : '0;
            end
            ST_HOLD: ad_oe_o = 1'b0;
            ST_HALT: ad_o = park_val;
            default: ad_o = '0;
        endcase
    end

    assign ctl_oe_o   = (q.state != ST_HOLD);
    assign ale_o      = (q.state == ST_ADDR);
    assign ale_no     = ~ale_o;
    assign ads_no     = ~(q.state == ST_ADDR);
    assign pa_o       = q.pa;
    assign hold_ack_o = (q.state == ST_HOLD);
    assign done_o     = q.done;
    assign rd_valid_o = q.rd_valid;
    assign rd_data_o  = q.rd_data;
    assign rd_idx_o   = q.rd_idx;

endmodule

// File: rtl/mbm_chk.sv
module mbm_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic ads_no,
    input logic ale_o,
    input logic ctl_oe_o,
    input logic ad_oe_o,
    input logic hold_ack_o,
    input logic done_o,
    input logic rd_valid_o,
    input logic rdy_i
);
    // R2
    ads_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ads_no |=> ads_no);

    // R3
    ale_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ale_o |=> !ale_o);

    // R4
    done_after_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(rdy_i));

    // R7
    rdv_after_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> ($past(rdy_i) && !$past(ad_oe_o)));

    // R8
    hold_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_ack_o |-> (!ctl_oe_o && !ad_oe_o));

    // R9
    hold_not_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ads_no |=> !hold_ack_o);

endmodule

bind mux_burst_master mbm_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ads_no     (ads_no),
    .ale_o      (ale_o),
    .ctl_oe_o   (ctl_oe_o),
    .ad_oe_o    (ad_oe_o),
    .hold_ack_o (hold_ack_o),
    .done_o     (done_o),
    .rd_valid_o (rd_valid_o),
    .rdy_i      (rdy_i)
);

// File: tb/mux_burst_master_tb.sv
module mux_burst_master_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_write, hold_req, halt, rdy;
    logic [31:0]  req_addr, ad_in;
    logic [1:0]   req_size, req_port;
    logic [127:0] req_wdata;
    logic [31:0]  ad_out, rd_data;
    logic         ad_oe, ctl_oe, ads_n, ale, ale_n, hold_ack, done, rd_valid;
    logic [3:0]   pa;
    logic [1:0]   rd_idx;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    mux_burst_master dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_size_i(req_size), .req_port_i(req_port), .req_wdata_i(req_wdata),
        .hold_req_i(hold_req), .halt_i(halt), .rdy_i(rdy), .ad_i(ad_in),
        .ad_o(ad_out), .ad_oe_o(ad_oe), .ctl_oe_o(ctl_oe), .ads_no(ads_n),
        .ale_o(ale), .ale_no(ale_n), .pa_o(pa), .hold_ack_o(hold_ack),
        .done_o(done), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_idx_o(rd_idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog expired actual=%0d expected<%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // one transaction; returns the last bus word seen and last partial address
    task automatic run_txn(input logic [1:0] pw, input logic [1:0] sz, input logic wr,
                           input logic [31:0] addr, input logic use_hold,
                           output logic [31:0] last_bus, output logic [3:0] last_pa);
        logic [31:0] mask;
        logic [3:0]  step, p;
        logic [31:0] w [4];
        logic [31:0] rp;
        mask = (pw == 2'd0) ? 32'h0000_00FF : (pw == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        step = (pw == 2'd0) ? 4'd1 : (pw == 2'd1) ? 4'd2 : 4'd4;
        p    = addr[3:0] & ((pw == 2'd0) ? 4'hF : (pw == 2'd1) ? 4'hE : 4'hC);
        last_bus = '0;
        last_pa  = '0;
        for (int i = 0; i < 4; i++) begin
            w[i] = 32'h8E3B_1C47 ^ addr ^ (32'h0101_0101 * (i + 1));
            req_wdata[i*32 +: 32] = w[i];
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_size = sz; req_port = pw; hold_req = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        hold_req  = use_hold;
        chk("R2 strobe", {31'd0, ads_n}, 32'd0);
        chk("R2 ale", {31'd0, ale}, 32'd1);
        chk("R3 ale_n", {31'd0, ale_n}, 32'd0);
        chk("R2 addr/size", ad_out, {addr[31:2], sz});
        chk("R5 pa init", {28'd0, pa}, {28'd0, p});
        @(negedge clk);
        for (int b = 0; b <= int'(sz); b++) begin
            chk("R3 ale low", {31'd0, ale}, 32'd0);
            chk("R3 strobe high", {31'd0, ads_n}, 32'd1);
            chk("R6/R7 ad_oe", {31'd0, ad_oe}, {31'd0, wr});
            if (wr) chk("R6 lanes", ad_out, w[b] & mask);
            chk("R5 pa step", {28'd0, pa}, {28'd0, p});
            if (use_hold) chk("R9 no hold", {31'd0, hold_ack}, 32'd0);
            if (b == 1) begin
                @(negedge clk);
                chk("R5 pa wait", {28'd0, pa}, {28'd0, p});
                chk("R4 no early done", {31'd0, done}, 32'd0);
            end
            rp = 32'hC3A5_0000 ^ {16'd0, addr[7:0], 8'(b * 17)};
            last_bus = w[b] & mask;
            last_pa  = p;
            rdy = 1'b1; ad_in = rp;
            @(negedge clk);
            rdy = 1'b0;
            if (!wr) begin
                chk("R7 rd_valid", {31'd0, rd_valid}, 32'd1);
                chk("R7 rd_data", rd_data, rp & mask);
                chk("R7 rd_idx", {30'd0, rd_idx}, b);
            end
            p = p + step;
        end
        chk("R4 done", {31'd0, done}, 32'd1);
        chk("R4 idle strobe", {31'd0, ads_n}, 32'd1);
        @(negedge clk);
        chk("R4 done pulse", {31'd0, done}, 32'd0);
        if (use_hold) begin
            chk("R9 hold after txn", {31'd0, hold_ack}, 32'd1);
            hold_req = 1'b0;
            @(negedge clk);
            chk("R8 released", {31'd0, hold_ack}, 32'd0);
        end
    endtask

    task automatic halt_test(input logic [31:0] exp, input string tag);
        halt = 1'b1;
        @(negedge clk);
        chk(tag, ad_out, exp);
        chk("R12 ad_oe halted", {31'd0, ad_oe}, 32'd1);
        req_valid = 1'b1;
        req_addr  = 32'h1234_5678;
        @(negedge clk);
        chk("R12 req ignored strobe", {31'd0, ads_n}, 32'd1);
        chk("R12 park kept", ad_out, exp);
        req_valid = 1'b0;
        halt = 1'b0;
        @(negedge clk);
        chk("R12 still idle", {31'd0, ads_n}, 32'd1);
    endtask

    initial begin
        logic [31:0] lb, a;
        logic [3:0]  lp;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; hold_req = 1'b0;
        halt = 1'b0; rdy = 1'b0; req_addr = '0; ad_in = '0;
        req_size = '0; req_port = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 strobe", {31'd0, ads_n}, 32'd1);
        chk("R1 ale", {31'd0, ale}, 32'd0);
        chk("R1 ale_n", {31'd0, ale_n}, 32'd1);
        chk("R1 ctl_oe", {31'd0, ctl_oe}, 32'd1);
        chk("R1 hold_ack", {31'd0, hold_ack}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;

        // sweep: port width x size x direction x start offset
        for (int pw = 0; pw < 4; pw++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    for (int k = 0; k < 4; k++) begin
                        a = 32'h9ABC_0000 ^ (k * 32'h0102_0307);
                        run_txn(2'(pw), 2'(sz), 1'(wr), a, 1'b0, lb, lp);
                    end
                end
            end
        end

        // R10 halt after write
        a = 32'h5566_7788;
        run_txn(2'd2, 2'd2, 1'b1, a, 1'b0, lb, lp);
        halt_test({lb[31:2], 2'd2}, "R10 park write");
        run_txn(2'd0, 2'd1, 1'b1, 32'h0F0F_00A3, 1'b0, lb, lp);
        halt_test({lb[31:2], 2'd1}, "R10 park write 8b");

        // R11 halt after read
        a = 32'hDEAD_BEEE;
        run_txn(2'd1, 2'd3, 1'b0, a, 1'b0, lb, lp);
        halt_test({a[31:4], lp[3:2], 2'd3}, "R11 park read");
        a = 32'h0123_4567;
        run_txn(2'd2, 2'd0, 1'b0, a, 1'b0, lb, lp);
        halt_test({a[31:4], lp[3:2], 2'd0}, "R11 park read 32b");

        // R8 hold in idle beats a pending request
        @(negedge clk);
        hold_req = 1'b1; req_valid = 1'b1; req_addr = 32'h7000_0000;
        @(negedge clk);
        chk("R8 hold_ack", {31'd0, hold_ack}, 32'd1);
        chk("R8 ctl float", {31'd0, ctl_oe}, 32'd0);
        chk("R8 ad float", {31'd0, ad_oe}, 32'd0);
        @(negedge clk);
        chk("R8 req ignored", {31'd0, hold_ack}, 32'd1);
        req_valid = 1'b0;
        hold_req  = 1'b0;
        @(negedge clk);
        chk("R8 resume ctl", {31'd0, ctl_oe}, 32'd1);
        chk("R8 resume strobe", {31'd0, ads_n}, 32'd1);
        chk("R8 resume ale", {31'd0, ale}, 32'd0);
        chk("R8 resume ack", {31'd0, hold_ack}, 32'd0);

        // R9 hold raised mid-burst
        run_txn(2'd2, 2'd3, 1'b1, 32'h4444_0008, 1'b1, lb, lp);
        run_txn(2'd0, 2'd2, 1'b0, 32'h4444_000F, 1'b1, lb, lp);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule